// File: doc/BRIEF.md
# NAND Interface Timing and Read-Delay Sequencer

This block applies an already solved timing set to a NAND flash interface. A configuration holds three cycle counts (address setup, data hold, data setup), a half-period flag for the read-strobe delay line and a sample delay factor. The block accepts it through a valid/ready handshake and then writes the interface controls one step per clock, in an order that never changes the delay line's settings while the line is running.

Each run loads the ready/busy timeout first and then the timing fields. Next it switches the delay line off and clears its delay and half-period settings. If the factor is nonzero, it sets the half-period bit when asked, writes the factor and switches the line back on. It raises `io_ready` only after the line has had its settle time. A factor of zero ends the run as soon as the settings are cleared, and the line stays off. The delay line is modelled by a settle counter and by a computed sample point.

The configuration port follows valid/ready rules. `cfg_ready` is high only while the sequencer is idle. A transfer takes place on a clock edge where both `cfg_valid` and `cfg_ready` are high. While a run is in progress, `cfg_ready` is low and `cfg_valid` and the configuration fields are ignored. The source may hold `cfg_valid` high and wait.

Top module: `nand_tim_seq`

## Requirements
- R1: `cfg_ready` is high after reset and whenever no run is in progress. A configuration is taken on an edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low in the cycle after that edge and stays low until the run ends. Configuration inputs presented while `cfg_ready` is low have no effect on any output.
- R2: A requested data setup or data hold of 0 is written as 1, because the interface reads 0 as its longest delay. An address setup of 0 is written unchanged, and every other value passes through unchanged.
- R3: The three timing outputs take the accepted values (after R2) on the second edge after acceptance.
- R4: `dly_factor` and `dly_half` change only when `dly_en` is 0 in the current cycle and was 0 in the previous cycle. `dly_en` goes to 0 on the third edge after acceptance, and factor and half go to 0 on the fourth.
- R5: When the accepted factor is 0, `dly_en`, `dly_half` and `dly_factor` all end at 0, and `io_ready` rises on the fourth edge after acceptance.
- R6: When the factor is nonzero, `dly_half` takes the requested flag on the fifth edge after acceptance and `dly_factor` takes the factor on the sixth. `dly_en` rises on the seventh. `io_ready` rises exactly SETTLE_CYC (default 64) edges after `dly_en` rises, which is edge 71 by default.
- R7: `rb_timeout` is 0 after reset and is loaded with TMO_VAL (default 0x500) on the first edge after every acceptance.
- R8: `io_ready` is 0 after reset. It falls in the cycle after an acceptance and stays 0 until the run completes.
- R9: `sample_ps` equals factor × CLK_PERIOD_PS / 8 when `dly_half` is 0, and factor × CLK_PERIOD_PS / 16 when it is 1. It is 0 while `dly_en` is 0.
- R10: After reset, `dly_en`, `dly_half`, `dly_factor` and `sample_ps` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | A configuration is offered |
| cfg_ready | output | 1 | Sequencer idle, a configuration can be taken |
| cfg_addr_setup | input | AS_W | Requested address setup cycles |
| cfg_data_hold | input | DH_W | Requested data hold cycles |
| cfg_data_setup | input | DS_W | Requested data setup cycles |
| cfg_half | input | 1 | Drive the delay line from half periods |
| cfg_factor | input | FAC_W | Sample delay factor, 0 means no delay line |
| tim_addr_setup | output | AS_W | Applied address setup field |
| tim_data_hold | output | DH_W | Applied data hold field |
| tim_data_setup | output | DS_W | Applied data setup field |
| rb_timeout | output | TMO_W | Ready/busy timeout field |
| dly_en | output | 1 | Delay line enable |
| dly_half | output | 1 | Delay line half-period select |
| dly_factor | output | FAC_W | Delay line factor field |
| io_ready | output | 1 | Interface may start I/O |
| sample_ps | output | SP_W | Modelled sample point in picoseconds |

## Verification
The bench targets these corner cases:
- A reprogram starting from a running delay line. A design that wrote the factor before switching the line off would change `dly_factor` while `dly_en` is still high.
- A factor of zero. A wrong design would still enable the line or would stall `io_ready` for the settle time.
- Zero setup and hold requests. A design without the clamp would leave the interface at its longest delay.
- The exact edge on which `io_ready` returns. An off-by-one settle counter moves it by one cycle.
- Configurations offered during a run. A design that accepts them would corrupt the applied fields.

// File: rtl/nts_pkg.sv
package nts_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TMO,
    ST_TIM,
    ST_DIS,
    ST_CLR,
    ST_HALF,
    ST_FACT,
    ST_EN,
    ST_SETTLE,
    ST_READY
  } nts_state_e;

endpackage

// File: rtl/nts_settle.sv
module nts_settle #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign done = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= LOAD;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: rtl/nts_sample.sv
module nts_sample #(
  parameter int FAC_W         = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SP_W          = 32
) (
  input  logic             en,
  input  logic             half,
  input  logic [FAC_W-1:0] factor,
  output logic [SP_W-1:0]  sample_ps
);
  localparam int FULL_SHIFT = 3;
  localparam logic [SP_W-1:0] PERIOD = SP_W'(CLK_PERIOD_PS);

  logic [SP_W-1:0] prod;

  assign prod = SP_W'(factor) * PERIOD;

  always_comb begin
    if (!en)       sample_ps = '0;
    else if (half) sample_ps = prod >> (FULL_SHIFT + 1);
    else           sample_ps = prod >> FULL_SHIFT;
  end

endmodule

// File: rtl/nts_ctrl.sv
module nts_ctrl
  import nts_pkg::*;
#(
  parameter int AS_W    = 6,
  parameter int DH_W    = 6,
  parameter int DS_W    = 8,
  parameter int FAC_W   = 8,
  parameter int TMO_W   = 16,
  parameter int TMO_VAL = 'h500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [AS_W-1:0]  cfg_addr_setup,
  input  logic [DH_W-1:0]  cfg_data_hold,
  input  logic [DS_W-1:0]  cfg_data_setup,
  input  logic             cfg_half,
  input  logic [FAC_W-1:0] cfg_factor,
  input  logic             settle_done,
  output logic             settle_start,
  output logic [AS_W-1:0]  tim_addr_setup,
  output logic [DH_W-1:0]  tim_data_hold,
  output logic [DS_W-1:0]  tim_data_setup,
  output logic [TMO_W-1:0] rb_timeout,
  output logic             dly_en,
  output logic             dly_half,
  output logic [FAC_W-1:0] dly_factor,
  output logic             io_ready
);
  nts_state_e st;

  logic [AS_W-1:0]  c_as;
  logic [DH_W-1:0]  c_dh;
  logic [DS_W-1:0]  c_ds;
  logic             c_half;
  logic [FAC_W-1:0] c_fac;
  logic             take;

  assign cfg_ready    = (st == ST_IDLE) || (st == ST_READY);
  assign io_ready     = (st == ST_READY);
  assign take         = cfg_valid && cfg_ready;
  assign settle_start = (st == ST_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_as   <= '0;
      c_dh   <= DH_W'(1);
      c_ds   <= DS_W'(1);
      c_half <= 1'b0;
      c_fac  <= '0;
    end else if (take) begin
      c_as   <= cfg_addr_setup;
      c_dh   <= (cfg_data_hold  == '0) ? DH_W'(1) : cfg_data_hold;
      c_ds   <= (cfg_data_setup == '0) ? DS_W'(1) : cfg_data_setup;
      c_half <= cfg_half;
      c_fac  <= cfg_factor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      tim_addr_setup <= '0;
      tim_data_hold  <= DH_W'(1);
      tim_data_setup <= DS_W'(1);
      rb_timeout     <= '0;
      dly_en         <= 1'b0;
      dly_half       <= 1'b0;
      dly_factor     <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_READY: if (take) st <= ST_TMO;
        ST_TMO: begin
          rb_timeout <= TMO_W'(TMO_VAL);
          st         <= ST_TIM;
        end
        ST_TIM: begin
          tim_addr_setup <= c_as;
          tim_data_hold  <= c_dh;
          tim_data_setup <= c_ds;
          st             <= ST_DIS;
        end
        ST_DIS: begin
          dly_en <= 1'b0;
          st     <= ST_CLR;
        end
        ST_CLR: begin
          dly_factor <= '0;
          dly_half   <= 1'b0;
          st         <= (c_fac == '0) ? ST_READY : ST_HALF;
        end
        ST_HALF: begin
          dly_half <= c_half;
          st       <= ST_FACT;
        end
        ST_FACT: begin
          dly_factor <= c_fac;
          st         <= ST_EN;
        end
        ST_EN: begin
          dly_en <= 1'b1;
          st     <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_done) st <= ST_READY;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !cfg_ready && !io_ready); // R1

  AST_NO_CHANGE_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dly_factor) || !$stable(dly_half)) |-> (!dly_en && !$past(dly_en))); // R4

  AST_ZERO_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ready && dly_factor == '0) |-> !dly_en && !dly_half); // R5

  AST_NONZERO_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |-> (tim_data_setup != '0) && (tim_data_hold != '0)); // R2

  AST_TMO_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |-> rb_timeout == TMO_W'(TMO_VAL)); // R7

endmodule

// File: rtl/nand_tim_seq.sv
module nand_tim_seq #(
  parameter int AS_W          = 6,
  parameter int DH_W          = 6,
  parameter int DS_W          = 8,
  parameter int FAC_W         = 8,
  parameter int TMO_W         = 16,
  parameter int TMO_VAL       = 'h500,
  parameter int SETTLE_CYC    = 64,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SP_W          = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [AS_W-1:0]  cfg_addr_setup,
  input  logic [DH_W-1:0]  cfg_data_hold,
  input  logic [DS_W-1:0]  cfg_data_setup,
  input  logic             cfg_half,
  input  logic [FAC_W-1:0] cfg_factor,
  output logic [AS_W-1:0]  tim_addr_setup,
  output logic [DH_W-1:0]  tim_data_hold,
  output logic [DS_W-1:0]  tim_data_setup,
  output logic [TMO_W-1:0] rb_timeout,
  output logic             dly_en,
  output logic             dly_half,
  output logic [FAC_W-1:0] dly_factor,
  output logic             io_ready,
  output logic [SP_W-1:0]  sample_ps
);
  localparam int AGE_W = $clog2(SETTLE_CYC + 1);

  logic settle_start;
  logic settle_done;

  nts_ctrl #(
    .AS_W(AS_W), .DH_W(DH_W), .DS_W(DS_W), .FAC_W(FAC_W),
    .TMO_W(TMO_W), .TMO_VAL(TMO_VAL)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr_setup(cfg_addr_setup), .cfg_data_hold(cfg_data_hold),
    .cfg_data_setup(cfg_data_setup), .cfg_half(cfg_half),
    .cfg_factor(cfg_factor),
    .settle_done(settle_done), .settle_start(settle_start),
    .tim_addr_setup(tim_addr_setup), .tim_data_hold(tim_data_hold),
    .tim_data_setup(tim_data_setup), .rb_timeout(rb_timeout),
    .dly_en(dly_en), .dly_half(dly_half), .dly_factor(dly_factor),
    .io_ready(io_ready)
  );

  nts_settle #(.CYC(SETTLE_CYC)) settle_i (
    .clk(clk), .rst_n(rst_n), .start(settle_start), .done(settle_done)
  );

  nts_sample #(
    .FAC_W(FAC_W), .CLK_PERIOD_PS(CLK_PERIOD_PS), .SP_W(SP_W)
  ) sample_i (
    .en(dly_en), .half(dly_half), .factor(dly_factor), .sample_ps(sample_ps)
  );

  // age of the enabled delay line, saturating at the settle time
  logic [AGE_W-1:0] en_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                en_age <= '0;
    else if (!dly_en)                          en_age <= '0;
    else if (en_age != AGE_W'(SETTLE_CYC))     en_age <= en_age + 1'b1;
  end

  AST_SETTLED_BEFORE_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ready && dly_en) |-> en_age == AGE_W'(SETTLE_CYC)); // R6

  AST_SAMPLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_en |-> sample_ps == '0); // R9

endmodule

// File: tb/nand_tim_seq_tb_top.sv
module nand_tim_seq_tb_top;
  localparam int TMO = 'h500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [5:0]  cfg_as = '0;
  logic [5:0]  cfg_dh = '0;
  logic [7:0]  cfg_ds = '0;
  logic        cfg_half = 1'b0;
  logic [7:0]  cfg_fac = '0;
  logic [5:0]  t_as;
  logic [5:0]  t_dh;
  logic [7:0]  t_ds;
  logic [15:0] rbto;
  logic        d_en, d_half, io_ready;
  logic [7:0]  d_fac;
  logic [31:0] sp;

  nand_tim_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr_setup(cfg_as), .cfg_data_hold(cfg_dh), .cfg_data_setup(cfg_ds),
    .cfg_half(cfg_half), .cfg_factor(cfg_fac),
    .tim_addr_setup(t_as), .tim_data_hold(t_dh), .tim_data_setup(t_ds),
    .rb_timeout(rbto), .dly_en(d_en), .dly_half(d_half), .dly_factor(d_fac),
    .io_ready(io_ready), .sample_ps(sp)
  );

  typedef struct packed {
    logic [5:0]  as;
    logic [5:0]  dh;
    logic [7:0]  ds;
    logic        half;
    logic [7:0]  fac;
    logic [5:0]  exp_dh;
    logic [7:0]  exp_ds;
    logic [31:0] exp_sp;
    logic [7:0]  exp_lat;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{6'd3,  6'd2,  8'd5,   1'b0, 8'd4,   6'd2,  8'd5,   32'd5000,   8'd71},
    '{6'd0,  6'd0,  8'd0,   1'b0, 8'd0,   6'd1,  8'd1,   32'd0,      8'd4},
    '{6'd63, 6'd63, 8'd255, 1'b1, 8'd255, 6'd63, 8'd255, 32'd159375, 8'd71},
    '{6'd1,  6'd0,  8'd7,   1'b1, 8'd1,   6'd1,  8'd7,   32'd625,    8'd71},
    '{6'd5,  6'd9,  8'd0,   1'b0, 8'd0,   6'd9,  8'd1,   32'd0,      8'd4},
    '{6'd2,  6'd1,  8'd1,   1'b0, 8'd200, 6'd1,  8'd1,   32'd250000, 8'd71}
  };

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // offer a configuration; returns at the negedge after the accepting edge
  task automatic offer(input logic [5:0] a, input logic [5:0] h, input logic [7:0] s,
                       input logic hf, input logic [7:0] f);
    @(negedge clk);
    cfg_as = a; cfg_dh = h; cfg_ds = s; cfg_half = hf; cfg_fac = f;
    cfg_valid = 1'b1;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!io_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10 / R7 / R8 / R1: reset state
    check(io_ready == 1'b0, "R8 reset io_ready", io_ready, 0);
    check(cfg_ready == 1'b1, "R1 reset cfg_ready", cfg_ready, 1);
    check(rbto == 16'd0, "R7 reset timeout", rbto, 0);
    check(d_en == 1'b0 && d_half == 1'b0 && d_fac == 8'd0, "R10 reset delay line",
          {d_en, d_half, d_fac}, 0);
    check(sp == 32'd0, "R10 reset sample_ps", sp, 0);
    rst_n = 1'b1;

    // vector table walk
    for (int i = 0; i < 6; i++) begin
      offer(VEC[i].as, VEC[i].dh, VEC[i].ds, VEC[i].half, VEC[i].fac);
      check(io_ready == 1'b0 && cfg_ready == 1'b0, "R8 R1 drop after accept",
            {io_ready, cfg_ready}, 0);
      wait_ready(lat);
      check(lat == int'(VEC[i].exp_lat), "R5 R6 ready latency", lat, VEC[i].exp_lat);
      check(t_as == VEC[i].as, "R3 addr setup", t_as, VEC[i].as);
      check(t_dh == VEC[i].exp_dh, "R2 data hold", t_dh, VEC[i].exp_dh);
      check(t_ds == VEC[i].exp_ds, "R2 data setup", t_ds, VEC[i].exp_ds);
      check(rbto == 16'(TMO), "R7 timeout value", rbto, TMO);
      check(d_en == (VEC[i].fac != 0), "R5 enable state", d_en, VEC[i].fac != 0);
      check(d_fac == VEC[i].fac, "R6 factor field", d_fac, VEC[i].fac);
      check(d_half == (VEC[i].half && VEC[i].fac != 0), "R5 R6 half bit", d_half,
            VEC[i].half && VEC[i].fac != 0);
      check(sp == VEC[i].exp_sp, "R9 sample point", sp, VEC[i].exp_sp);
    end

    // directed: reprogram from a running line, step by step (line now on, factor 200)
    offer(6'd4, 6'd3, 8'd6, 1'b1, 8'd16);
    // at N0: nothing applied yet beyond acceptance
    @(negedge clk); // N1
    check(rbto == 16'(TMO), "R7 timeout on first edge", rbto, TMO);
    check(t_ds == 8'd1, "R3 timing not yet written", t_ds, 1);
    @(negedge clk); // N2
    check(t_as == 6'd4 && t_dh == 6'd3 && t_ds == 8'd6, "R3 timing on edge two",
          {t_as, t_dh, t_ds}, {6'd4, 6'd3, 8'd6});
    check(d_en == 1'b1 && d_fac == 8'd200, "R4 line untouched on edge two", {d_en, d_fac},
          {1'b1, 8'd200});
    @(negedge clk); // N3
    check(d_en == 1'b0 && d_fac == 8'd200, "R4 disable before field change",
          {d_en, d_fac}, {1'b0, 8'd200});
    @(negedge clk); // N4
    check(d_fac == 8'd0 && d_half == 1'b0, "R4 fields cleared", {d_half, d_fac}, 0);
    @(negedge clk); // N5
    check(d_half == 1'b1 && d_fac == 8'd0, "R6 half set first", {d_half, d_fac}, {1'b1, 8'd0});
    @(negedge clk); // N6
    check(d_fac == 8'd16 && d_en == 1'b0, "R6 factor before enable", {d_en, d_fac},
          {1'b0, 8'd16});
    // R1: offer other values during the run; must be ignored
    cfg_as = 6'd60; cfg_dh = 6'd60; cfg_ds = 8'd99; cfg_half = 1'b0; cfg_fac = 8'd3;
    cfg_valid = 1'b1;
    @(negedge clk); // N7
    check(d_en == 1'b1 && sp == 32'd10000, "R6 R9 enabled half-period", sp, 10000);
    check(cfg_ready == 1'b0, "R1 busy during settle", cfg_ready, 0);
    repeat (63) @(negedge clk); // N70
    check(io_ready == 1'b0, "R6 still settling one edge before", io_ready, 1'b0);
    cfg_valid = 1'b0;
    @(negedge clk); // N71
    check(io_ready == 1'b1, "R6 ready after settle", io_ready, 1'b1);
    check(t_ds == 8'd6 && d_fac == 8'd16 && t_as == 6'd4, "R1 busy offer ignored",
          {t_as, t_ds, d_fac}, {6'd4, 8'd6, 8'd16});

    // R4 / R5: zero factor after a running line turns it fully off
    offer(6'd0, 6'd2, 8'd2, 1'b1, 8'd0);
    wait_ready(lat);
    check(lat == 4, "R5 zero factor latency", lat, 4);
    check(d_en == 1'b0 && d_half == 1'b0 && sp == 32'd0, "R5 line off", {d_en, d_half, sp}, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule